// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block is the digital back end of a clock fanout generator. It receives one fast source clock, expressed as a one-cycle enable pulse in the system clock domain, and turns it into three banks of output clocks and one dedicated feedback clock. The source is either a modelled oscillator tick or, in bypass mode, one of two reference ticks chosen by a select input. A prescaler divides the source by 2 or 4. Each bank then applies its own pair of even divide ratios to the prescaled tick. Because every output is counted from the same chain, all outputs keep a fixed phase relationship.

All counters start together when the active-low master reset is released. Frequency selects are captured only when the whole chain returns to its common alignment point, so reprogramming never produces a shortened pulse. The output enable forces the three banks low without stopping the feedback clock, so an external loop can acquire lock before the rest of the system is clocked. Each output also has a drive enable that is low (high impedance) while reset is held. A flag reports a loop-feedback choice whose total division from the source is below 8.

Top module: `clk_fanout_div`

## Requirements
- R1: The prescaler divides source ticks by 2 when `src_div4` is 0 and by 4 when it is 1.
- R2: Bank A and bank B each divide the prescaled tick by 2 when their select (`sel_a`, `sel_b`) is 0 and by 4 when it is 1, so the total division from the source is 4, 8 or 16.
- R3: Bank C divides the prescaled tick by 4 when `sel_c` is 0 and by 6 when it is 1.
- R4: The feedback output divides the prescaled tick by the ratio picked by `fb_ratio`: 2'b00 gives /4, 2'b01 gives /6, 2'b10 gives /8 and 2'b11 gives /12.
- R5: With D the total division from the source and s the number of source ticks since reset release or since the last frame alignment, an output is high while (s mod D) < D/2 and low otherwise, giving an exact 50% duty cycle; every output is high right after each alignment point.
- R6: On a clock edge that samples `mr_n` low, all counters clear, every bit of `drive_en` goes to 0 (high impedance for all 15 outputs, feedback included) and `cfg_bad` clears; `drive_en` returns to all ones on the first edge that samples `mr_n` high.
- R7: While `oe` is 0, `bank_a`, `bank_b` and `bank_c` read 0 at once, without waiting for a clock edge, while `fb_clk` keeps toggling; when `oe` returns to 1 the banks show their running levels immediately.
- R8: When `pll_on` is 1 the chain counts `vco_tick`; when it is 0 the chain counts `ref0_tick` if `ref_sel` is 0 and `ref1_tick` if `ref_sel` is 1, and the unselected ticks have no effect.
- R9: Changes to `src_div4`, `sel_a`, `sel_b`, `sel_c` and `fb_ratio` take effect only at the alignment point, reached after 24 prescaled ticks, or while reset is held.
- R10: One edge after the inputs are sampled, `cfg_bad` is 1 when the output named by `fb_src` (0 = dedicated feedback, 1 = bank A, 2 = bank B, 3 = bank C) has a total division from the source below 8, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| mr_n | input | 1 | Active-low master reset, sampled synchronously |
| vco_tick | input | 1 | One-cycle pulse per oscillator source edge |
| ref0_tick | input | 1 | One-cycle pulse per edge of reference 0 |
| ref1_tick | input | 1 | One-cycle pulse per edge of reference 1 |
| ref_sel | input | 1 | Reference choice in bypass: 0 = reference 0, 1 = reference 1 |
| pll_on | input | 1 | 1 = count oscillator ticks, 0 = bypass to the selected reference |
| src_div4 | input | 1 | Prescaler ratio: 0 = /2, 1 = /4 |
| sel_a | input | 1 | Bank A ratio: 0 = /2, 1 = /4 |
| sel_b | input | 1 | Bank B ratio: 0 = /2, 1 = /4 |
| sel_c | input | 1 | Bank C ratio: 0 = /4, 1 = /6 |
| fb_ratio | input | 2 | Feedback ratio: 00 /4, 01 /6, 10 /8, 11 /12 |
| fb_src | input | 2 | Output used as loop feedback, for the validity check |
| oe | input | 1 | 1 = banks run, 0 = banks held low (feedback unaffected) |
| bank_a | output | 5 | Bank A clock outputs |
| bank_b | output | 5 | Bank B clock outputs |
| bank_c | output | 4 | Bank C clock outputs |
| fb_clk | output | 1 | Dedicated feedback clock output |
| drive_en | output | 15 | Per-output drive enables: [4:0] bank A, [9:5] bank B, [13:10] bank C, [14] feedback |
| cfg_bad | output | 1 | Feedback configuration unstable |

## Verification
On every cycle the assertions check that the prescaler phase never passes the active ratio, that the frame counter stays inside its frame, that the active configuration changes only at an alignment edge, that each divider level moves only on a prescaled tick, that all outputs are high right after alignment, that reset removes every drive enable, and that a raised feedback flag never names the dedicated feedback output. The exact divide ratios, the 50% duty cycle, the source selection in bypass, the deferral of reprogramming to the next frame and the immediate gating by the output enable can be shown only by the bench's scenarios, whose reference model counts source ticks and predicts every output level from the tick count and the captured configuration.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Prescaled ticks in one alignment frame: least common multiple of all bank ratios.
  localparam int FRAME_LEN = 24;
  localparam int NUM_DIV   = 4;   // bank A, bank B, bank C, feedback
  localparam int HALF_W    = 3;   // wide enough for the largest half period (6)
  localparam int TOTAL_W   = 6;   // wide enough for the largest total ratio (48)
  localparam int UNSTABLE_BELOW = 8;

  localparam int IDX_A  = 0;
  localparam int IDX_B  = 1;
  localparam int IDX_C  = 2;
  localparam int IDX_FB = 3;

  typedef struct packed {
    logic       pre4;    // prescaler /4 instead of /2
    logic       a4;      // bank A /4 instead of /2
    logic       b4;      // bank B /4 instead of /2
    logic       c6;      // bank C /6 instead of /4
    logic [1:0] fbr;     // feedback ratio code
  } div_cfg_t;

  // Half period, in prescaled ticks, of divider idx under configuration c.
  function automatic logic [HALF_W-1:0] half_of(input div_cfg_t c, input int idx);
    logic [HALF_W-1:0] h;
    case (idx)
      IDX_A:   h = c.a4 ? 3'd2 : 3'd1;
      IDX_B:   h = c.b4 ? 3'd2 : 3'd1;
      IDX_C:   h = c.c6 ? 3'd3 : 3'd2;
      default: begin
        case (c.fbr)
          2'b00:   h = 3'd2;
          2'b01:   h = 3'd3;
          2'b10:   h = 3'd4;
          default: h = 3'd6;
        endcase
      end
    endcase
    return h;
  endfunction

  // Total division from the source to divider idx: prescaler * 2 * half.
  function automatic logic [TOTAL_W-1:0] total_of(input div_cfg_t c, input int idx);
    logic [TOTAL_W-1:0] h;
    h = {{(TOTAL_W-HALF_W){1'b0}}, half_of(c, idx)};
    return c.pre4 ? (h << 3) : (h << 2);
  endfunction

endpackage

// File: rtl/cd_src_pick.sv
module cd_src_pick (
  input  logic vco_tick,
  input  logic ref0_tick,
  input  logic ref1_tick,
  input  logic ref_sel,
  input  logic pll_on,
  output logic src_tick
);

  logic ref_tick;

  always_comb begin
    ref_tick = ref_sel ? ref1_tick : ref0_tick;
    src_tick = pll_on ? vco_tick : ref_tick;
  end

endmodule

// File: rtl/cd_phase_ctl.sv
module cd_phase_ctl
  import clkdiv_pkg::*;
#(
  parameter int FRAME = FRAME_LEN,
  parameter int PRE_W = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     src_tick,
  input  div_cfg_t cfg_in,
  output logic     pre_tick,
  output logic     wrap,
  output div_cfg_t cfg_act
);

  localparam int FW = $clog2(FRAME);

  logic [PRE_W-1:0] pc;
  logic [FW-1:0]    fc;
  logic [PRE_W-1:0] pre_last;

  always_comb begin
    pre_last = cfg_act.pre4 ? PRE_W'(3) : PRE_W'(1);
    pre_tick = src_tick && (pc == pre_last);
    wrap     = pre_tick && (fc == FW'(FRAME - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc      <= '0;
      fc      <= '0;
      cfg_act <= cfg_in;
    end else begin
      if (src_tick) begin
        pc <= (pc == pre_last) ? '0 : pc + 1'b1;
      end
      if (pre_tick) begin
        fc <= wrap ? '0 : fc + 1'b1;
      end
      if (wrap) begin
        cfg_act <= cfg_in;
      end
    end
  end

  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (rst)
    (pc != '0) |-> (pc <= pre_last));

  assert_frame_bound_R9: assert property (@(posedge clk) disable iff (rst)
    fc < FW'(FRAME));

  assert_cfg_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (cfg_act != $past(cfg_act))) |-> $past(wrap));

endmodule

// File: rtl/cd_half_div.sv
module cd_half_div
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wrap,
  input  logic [HALF_W-1:0] half,
  output logic              lvl
);

  logic [HALF_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      lvl <= 1'b1;
    end else if (wrap) begin
      cnt <= '0;
      lvl <= 1'b1;
    end else if (tick) begin
      if (cnt == half - 1'b1) begin
        cnt <= '0;
        lvl <= ~lvl;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_lvl_on_tick_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (lvl != $past(lvl))) |-> $past(tick));

endmodule

// File: rtl/clk_fanout_div.sv
module clk_fanout_div
  import clkdiv_pkg::*;
#(
  parameter int NA   = 5,
  parameter int NB   = 5,
  parameter int NC   = 4,
  parameter int NOUT = NA + NB + NC + 1
) (
  input  logic            clk,
  input  logic            mr_n,
  input  logic            vco_tick,
  input  logic            ref0_tick,
  input  logic            ref1_tick,
  input  logic            ref_sel,
  input  logic            pll_on,
  input  logic            src_div4,
  input  logic            sel_a,
  input  logic            sel_b,
  input  logic            sel_c,
  input  logic [1:0]      fb_ratio,
  input  logic [1:0]      fb_src,
  input  logic            oe,
  output logic [NA-1:0]   bank_a,
  output logic [NB-1:0]   bank_b,
  output logic [NC-1:0]   bank_c,
  output logic            fb_clk,
  output logic [NOUT-1:0] drive_en,
  output logic            cfg_bad
);

  logic         rst;
  logic         src_tick;
  logic         pre_tick;
  logic         wrap;
  div_cfg_t     cfg_in;
  div_cfg_t     cfg_act;
  logic [NUM_DIV-1:0] lvl;
  logic         drv;
  logic         bad_now;
  int           fb_idx;

  always_comb begin
    rst    = ~mr_n;
    cfg_in = '{pre4: src_div4, a4: sel_a, b4: sel_b, c6: sel_c, fbr: fb_ratio};
  end

  cd_src_pick u_pick (
    .vco_tick  (vco_tick),
    .ref0_tick (ref0_tick),
    .ref1_tick (ref1_tick),
    .ref_sel   (ref_sel),
    .pll_on    (pll_on),
    .src_tick  (src_tick)
  );

  cd_phase_ctl #(.FRAME(FRAME_LEN)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .src_tick (src_tick),
    .cfg_in   (cfg_in),
    .pre_tick (pre_tick),
    .wrap     (wrap),
    .cfg_act  (cfg_act)
  );

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
    cd_half_div u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (pre_tick),
      .wrap (wrap),
      .half (half_of(cfg_act, g)),
      .lvl  (lvl[g])
    );
  end

  // Bank gating by the output enable is deliberately not re-timed.
  always_comb begin
    bank_a   = {NA{lvl[IDX_A] & oe}};
    bank_b   = {NB{lvl[IDX_B] & oe}};
    bank_c   = {NC{lvl[IDX_C] & oe}};
    fb_clk   = lvl[IDX_FB];
    drive_en = {NOUT{drv}};
  end

  always_comb begin
    case (fb_src)
      2'd1:    fb_idx = IDX_A;
      2'd2:    fb_idx = IDX_B;
      2'd3:    fb_idx = IDX_C;
      default: fb_idx = IDX_FB;
    endcase
    bad_now = total_of(cfg_in, fb_idx) < TOTAL_W'(UNSTABLE_BELOW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv     <= 1'b0;
      cfg_bad <= 1'b0;
    end else begin
      drv     <= 1'b1;
      cfg_bad <= bad_now;
    end
  end

  assert_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (&lvl));

  assert_hiz_reset_R6: assert property (@(posedge clk)
    !mr_n |=> (drive_en == '0));

  assert_fb_never_bad_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && cfg_bad) |-> ($past(fb_src) != 2'd0));

endmodule

// File: tb/tb_clk_fanout_div.sv
module tb_clk_fanout_div;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        mr_n = 1'b0;
  logic        vco_tick = 1'b0, ref0_tick = 1'b0, ref1_tick = 1'b0;
  logic        ref_sel = 1'b0, pll_on = 1'b1;
  logic        src_div4 = 1'b0, sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
  logic [1:0]  fb_ratio = 2'b00, fb_src = 2'b00;
  logic        oe = 1'b1;
  logic [4:0]  bank_a, bank_b;
  logic [3:0]  bank_c;
  logic        fb_clk;
  logic [14:0] drive_en;
  logic        cfg_bad;

  clk_fanout_div dut (
    .clk(clk), .mr_n(mr_n), .vco_tick(vco_tick), .ref0_tick(ref0_tick),
    .ref1_tick(ref1_tick), .ref_sel(ref_sel), .pll_on(pll_on),
    .src_div4(src_div4), .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .fb_ratio(fb_ratio), .fb_src(fb_src), .oe(oe), .bank_a(bank_a),
    .bank_b(bank_b), .bank_c(bank_c), .fb_clk(fb_clk),
    .drive_en(drive_en), .cfg_bad(cfg_bad)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string scen = "R6";
  bit    finished = 0;

  // Expected item: {drive, bad, lvl_a, lvl_b, lvl_c, lvl_fb}; oe gating is applied at sampling.
  logic [5:0] exp_q[$];

  // Reference model state
  int s_m = 0;
  int pre_m = 2, da = 4, db = 4, dc = 8, dfb = 8;

  task automatic load_cfg();
    pre_m = src_div4 ? 4 : 2;
    da    = pre_m * (sel_a ? 4 : 2);
    db    = pre_m * (sel_b ? 4 : 2);
    dc    = pre_m * (sel_c ? 6 : 4);
    case (fb_ratio)
      2'b00:   dfb = pre_m * 4;
      2'b01:   dfb = pre_m * 6;
      2'b10:   dfb = pre_m * 8;
      default: dfb = pre_m * 12;
    endcase
  endtask

  function automatic logic lv(int d);
    return (s_m % d) < (d / 2);
  endfunction

  always @(posedge clk) begin : model
    logic drv_m, bad_m, tk;
    int   pre_in;
    if (!mr_n) begin
      s_m = 0;
      load_cfg();
      drv_m = 1'b0;
      bad_m = 1'b0;
    end else begin
      drv_m  = 1'b1;
      pre_in = src_div4 ? 4 : 2;
      case (fb_src)
        2'd1:    bad_m = (pre_in * (sel_a ? 4 : 2)) < 8;
        2'd2:    bad_m = (pre_in * (sel_b ? 4 : 2)) < 8;
        default: bad_m = 1'b0;
      endcase
      tk = pll_on ? vco_tick : (ref_sel ? ref1_tick : ref0_tick);
      if (tk) begin
        s_m++;
        if (s_m == pre_m * 24) begin
          s_m = 0;
          load_cfg();
        end
      end
    end
    exp_q.push_back({drv_m, bad_m, lv(da), lv(db), lv(dc), lv(dfb)});
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) at %0t: got %h expected %h", tag, scen, $time, got, exp);
    end
  endtask

  // Monitor: pops the expected item and compares halfway through the cycle.
  always @(negedge clk) begin : monitor
    logic [5:0] e;
    if (!finished && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk("R6 drive", 16'(drive_en), e[5] ? 16'h7fff : 16'h0000);
      chk("R10 cfg_bad", 16'(cfg_bad), 16'(e[4]));
      chk("R2 bank_a", 16'(bank_a), 16'({5{e[3] & oe}}));
      chk("R2 bank_b", 16'(bank_b), 16'({5{e[2] & oe}}));
      chk("R3 bank_c", 16'(bank_c), 16'({4{e[1] & oe}}));
      chk("R4 fb_clk", 16'(fb_clk), 16'(e[0]));
    end
  end

  // Source tick generator: changes 2 ns after each rising edge.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      vco_tick  = ($urandom % 4) != 0;
      ref0_tick = (cyc % 2) == 0;
      ref1_tick = (cyc % 3) == 0;
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic summary();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog (%s): got timeout expected completion", scen);
    summary();
  end

  initial begin
    scen = "R6 reset hold";    run(6);
    mr_n = 1'b1;
    scen = "R2 default";       run(300);
    sel_b = 1'b1;
    scen = "R9 mid-frame b";   run(300);
    src_div4 = 1'b1;
    scen = "R1 prescale4";     run(400);
    sel_c = 1'b1; fb_ratio = 2'b11;
    scen = "R3 c6 fb12";       run(500);
    fb_ratio = 2'b01;
    scen = "R4 fb6";           run(300);
    fb_ratio = 2'b10;
    scen = "R4 fb8";           run(400);
    src_div4 = 1'b0; sel_a = 1'b1;
    scen = "R5 duty";          run(300);
    oe = 1'b0;
    scen = "R7 oe low";        run(150);
    oe = 1'b1;
    scen = "R7 oe high";       run(50);
    pll_on = 1'b0; ref_sel = 1'b0;
    scen = "R8 ref0";          run(300);
    ref_sel = 1'b1;
    scen = "R8 ref1";          run(300);
    pll_on = 1'b1;
    sel_a = 1'b0; src_div4 = 1'b0; fb_src = 2'd1;
    scen = "R10 bank a /4";    run(20);
    fb_src = 2'd2; sel_b = 1'b1;
    scen = "R10 bank b /8";    run(20);
    sel_b = 1'b0;
    scen = "R10 bank b /4";    run(20);
    fb_src = 2'd3;
    scen = "R10 bank c";       run(20);
    src_div4 = 1'b1; fb_src = 2'd1;
    scen = "R10 prescale4";    run(20);
    fb_src = 2'd0;
    mr_n = 1'b0;
    scen = "R6 mid reset";     run(5);
    mr_n = 1'b1;
    scen = "R6 restart";       run(200);
    run(2);
    summary();
  end

endmodule